// File: doc/BRIEF.md
# Flash Interrupt and Status Register Group

This block holds the interrupt and error bookkeeping of a NAND-style flash controller. It sits on a 16-bit register bus with separate read and write strobes and keeps four registers: a controller status word with per-operation error flags, an interrupt status word with per-completion flags and a master bit, and two system configuration words. A command engine outside the block reports completions and failures through single-cycle event inputs. The block turns them into register bits, an interrupt line whose polarity software selects, and a ready line.

The block also gates new commands. A command write is accepted only while the master interrupt bit is clear. An accepted code that is recognised goes to the engine as a one-cycle go pulse carrying the code. A code that is not recognised raises the command error flag and the master bit instead. The two reset codes also return the register group to its warm reset values.

Top module: `flash_irq_unit`

## Requirements
- R1: After the asynchronous cold reset (rst_n low), the interrupt register reads 0x8080, controller status reads 0, configuration 1 reads 0x40C0, configuration 2 reads 0, ready_o is 1 and irq_o is 1.
- R2: A warm_rst pulse, or an accepted command code 0x00F0 or 0x00F3, sets the interrupt register to 0x8010, controller status and configuration 2 to 0, configuration 1 to 0x40C0 and ready_o to 1. The command register then reads 0. A reset code still produces a cmd_go pulse.
- R3: irq_o is registered. One cycle after the register values it depends on, it equals interrupt bit 15 XOR NOT configuration-1 bit 6, so bit 6 = 1 gives an active-high line and bit 6 = 0 an inverted one.
- R4: A write to the interrupt register (address 1) ANDs the written value into it. If bit 15 is then clear, controller status bits 10 to 13 are cleared.
- R5: A write to the command register (address 4) while interrupt bit 15 is set is ignored: no cmd_go, command register and status unchanged.
- R6: done_ev[i] sets interrupt bit 4+i (0 reset, 1 erase, 2 program, 3 load) and bit 15 in the same cycle. done_any sets only bit 15. An event wins over a clearing write in the same cycle.
- R7: fail_ev[i] sets controller status bit 10+i (0 command, 1 erase, 2 program, 3 load).
- R8: Each write to configuration 1 (address 2) loads ready_o with bit 7 of the written value in the same cycle that the register updates.
- R9: Configuration 1 reads back with bits 4:0 forced to 0. Configuration 2 (address 3) reads back all 16 bits. Controller status is at address 0.
- R10: An accepted command write stores the code, which reads back at address 4. A recognised code (0x00, 0x13, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x80, 0x94, 0x95, 0xB0, 0xF0, 0xF3, upper byte zero) gives a one-cycle cmd_go with cmd_code equal to the code. Any other code sets status bit 10 and interrupt bit 15 with no cmd_go.
- R11: reg_rdata is registered: it shows the addressed register one cycle after reg_rd and holds its value otherwise. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous warm reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| done_ev | input | 4 | Completion events: reset, erase, program, load |
| done_any | input | 1 | Completion that raises only the master bit |
| fail_ev | input | 4 | Error events: command, erase, program, load |
| irq_o | output | 1 | Interrupt line, polarity from configuration 1 bit 6 |
| ready_o | output | 1 | Ready line |
| cmd_go | output | 1 | One-cycle pulse for an accepted recognised command |
| cmd_code | output | 16 | Code that goes with cmd_go |

## Verification
A wrong interrupt or status bit shows on irq_o one cycle after the bad register update, and on reg_rdata on the first read that follows. A wrong acceptance decision shows in the very next cycle as a missing or extra cmd_go pulse. It also shows in the command error flag and the master bit. The sweeps step through both polarities against both master states, every event bit, clearing writes with and without a colliding event, and all 256 low command codes, so any mis-steered bit appears within two cycles of its stimulus.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
    localparam int DATA_W      = 16;
    localparam int N_EVENTS    = 4;

    // interrupt register bit positions
    localparam int INT_MASTER  = 15;
    localparam int INT_EV_BASE = 4;
    // controller status bit positions
    localparam int ST_ERR_BASE = 10;
    // configuration 1 bit positions
    localparam int CFG1_POL    = 6;
    localparam int CFG1_RDY    = 7;
    localparam int CFG1_MASKED = 5;

    // register offsets
    localparam int REG_STATUS  = 0;
    localparam int REG_INT     = 1;
    localparam int REG_CFG1    = 2;
    localparam int REG_CFG2    = 3;
    localparam int REG_CMD     = 4;

    localparam logic [DATA_W-1:0] INT_COLD  = 16'h8080;
    localparam logic [DATA_W-1:0] INT_WARM  = 16'h8010;
    localparam logic [DATA_W-1:0] CFG1_INIT = 16'h40C0;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] intst;
        logic [DATA_W-1:0] cfg1;
        logic [DATA_W-1:0] cfg2;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] code;
        logic [DATA_W-1:0] rdata;
        logic              irq;
        logic              rdy;
        logic              go;
    } unit_state_t;

    function automatic logic code_known(input logic [DATA_W-1:0] c);
        case (c)
            16'h0000, 16'h0013, 16'h001A, 16'h001B, 16'h0023, 16'h0027,
            16'h002A, 16'h002C, 16'h0030, 16'h0065, 16'h0071, 16'h0080,
            16'h0094, 16'h0095, 16'h00B0, 16'h00F0, 16'h00F3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic code_is_reset(input logic [DATA_W-1:0] c);
        return (c == 16'h00F0) || (c == 16'h00F3);
    endfunction
endpackage

// File: rtl/flash_irq_cmd_gate.sv
module flash_irq_cmd_gate
    import flash_irq_pkg::*;
(
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] code,
    input  logic              master_q,
    output logic              accept,
    output logic              known,
    output logic              soft_reset
);
    always_comb begin
        accept     = cmd_wr && !master_q;
        known      = code_known(code);
        soft_reset = accept && known && code_is_reset(code);
    end
endmodule

// File: rtl/flash_irq_rd_mux.sv
module flash_irq_rd_mux
    import flash_irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] intst,
    input  logic [DATA_W-1:0] cfg1,
    input  logic [DATA_W-1:0] cfg2,
    input  logic [DATA_W-1:0] cmd,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        case (int'(addr))
            REG_STATUS: value = status;
            REG_INT:    value = intst;
            REG_CFG1:   value = {cfg1[DATA_W-1:CFG1_MASKED], {CFG1_MASKED{1'b0}}};
            REG_CFG2:   value = cfg2;
            REG_CMD:    value = cmd;
            default:    value = '0;
        endcase
    end
endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit
    import flash_irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [3:0]        done_ev,
    input  logic              done_any,
    input  logic [3:0]        fail_ev,
    output logic              irq_o,
    output logic              ready_o,
    output logic              cmd_go,
    output logic [15:0]       cmd_code
);
    unit_state_t q, d;

    logic              wr_int, wr_cfg1, wr_cfg2, wr_cmd;
    logic              accept, known, soft_reset;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] int_q, status_q, cfg1_q;

    always_comb begin
        wr_int  = reg_wr && (int'(reg_addr) == REG_INT);
        wr_cfg1 = reg_wr && (int'(reg_addr) == REG_CFG1);
        wr_cfg2 = reg_wr && (int'(reg_addr) == REG_CFG2);
        wr_cmd  = reg_wr && (int'(reg_addr) == REG_CMD);
    end

    flash_irq_cmd_gate u_gate (
        .cmd_wr     (wr_cmd),
        .code       (reg_wdata),
        .master_q   (q.intst[INT_MASTER]),
        .accept     (accept),
        .known      (known),
        .soft_reset (soft_reset)
    );

    flash_irq_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
        .addr   (reg_addr),
        .status (q.status),
        .intst  (q.intst),
        .cfg1   (q.cfg1),
        .cfg2   (q.cfg2),
        .cmd    (q.cmd),
        .value  (rd_value)
    );

    always_comb begin
        d    = q;
        d.go = 1'b0;

        if (wr_cfg1) begin
            d.cfg1 = reg_wdata;
            d.rdy  = reg_wdata[CFG1_RDY];
        end
        if (wr_cfg2) begin
            d.cfg2 = reg_wdata;
        end
        if (wr_int) begin
            d.intst = q.intst & reg_wdata;
        end

        if (accept) begin
            d.cmd = reg_wdata;
            if (known) begin
                d.go   = 1'b1;
                d.code = reg_wdata;
            end else begin
                d.status[ST_ERR_BASE] = 1'b1;
                d.intst[INT_MASTER]   = 1'b1;
            end
        end

        // completion events take priority over a clearing write
        for (int i = 0; i < N_EVENTS; i++) begin
            if (done_ev[i]) begin
                d.intst[INT_EV_BASE + i] = 1'b1;
                d.intst[INT_MASTER]      = 1'b1;
            end
        end
        if (done_any) begin
            d.intst[INT_MASTER] = 1'b1;
        end

        if (wr_int && !d.intst[INT_MASTER]) begin
            d.status[ST_ERR_BASE + N_EVENTS - 1 : ST_ERR_BASE] = '0;
        end

        for (int i = 0; i < N_EVENTS; i++) begin
            if (fail_ev[i]) begin
                d.status[ST_ERR_BASE + i] = 1'b1;
            end
        end

        d.irq = q.intst[INT_MASTER] ^ ~q.cfg1[CFG1_POL];

        if (reg_rd) begin
            d.rdata = rd_value;
        end

        if (warm_rst || soft_reset) begin
            d.status = '0;
            d.intst  = INT_WARM;
            d.cfg1   = CFG1_INIT;
            d.cfg2   = '0;
            d.cmd    = '0;
            d.rdy    = 1'b1;
            if (warm_rst) begin
                d.go = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.status <= '0;
            q.intst  <= INT_COLD;
            q.cfg1   <= CFG1_INIT;
            q.cfg2   <= '0;
            q.cmd    <= '0;
            q.code   <= '0;
            q.rdata  <= '0;
            q.irq    <= 1'b1;
            q.rdy    <= 1'b1;
            q.go     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        int_q    = q.intst;
        status_q = q.status;
        cfg1_q   = q.cfg1;
    end

    assign reg_rdata = q.rdata;
    assign irq_o     = q.irq;
    assign ready_o   = q.rdy;
    assign cmd_go    = q.go;
    assign cmd_code  = q.code;
endmodule

// File: rtl/flash_irq_unit_chk.sv
module flash_irq_unit_chk
    import flash_irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              warm_rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [15:0]       reg_wdata,
    input logic [3:0]        done_ev,
    input logic              done_any,
    input logic [3:0]        fail_ev,
    input logic              irq_o,
    input logic              ready_o,
    input logic              cmd_go,
    input logic [15:0]       int_q,
    input logic [15:0]       status_q,
    input logic [15:0]       cfg1_q
);
    logic cmd_wr_c, int_wr_c, cfg1_wr_c;
    assign cmd_wr_c  = reg_wr && (int'(reg_addr) == REG_CMD);
    assign int_wr_c  = reg_wr && (int'(reg_addr) == REG_INT);
    assign cfg1_wr_c = reg_wr && (int'(reg_addr) == REG_CFG1);

    // R5
    a_r5_cmd_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_c && int_q[15] && !warm_rst) |=> !cmd_go);

    // R3
    a_r3_irq_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == ($past(int_q[15]) ^ ~$past(cfg1_q[6]))));

    // R4
    a_r4_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr_c && !reg_wdata[15] && !done_any && (done_ev == 4'b0)
         && (fail_ev == 4'b0) && !warm_rst)
        |=> (!int_q[15] && (status_q[13:10] == 4'b0)));

    // R6
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_ev != 4'b0) && !warm_rst && !cmd_wr_c)
        |=> (int_q[15] && ((int_q[7:4] & $past(done_ev)) == $past(done_ev))));

    // R7
    a_r7_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((fail_ev != 4'b0) && !warm_rst && !cmd_wr_c)
        |=> ((status_q[13:10] & $past(fail_ev)) == $past(fail_ev)));

    // R8
    a_r8_ready_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg1_wr_c && !warm_rst) |=> (ready_o == $past(reg_wdata[7])));

    // R2
    a_r2_warm_values: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> ((int_q == 16'h8010) && (status_q == 16'h0) && ready_o));
endmodule

bind flash_irq_unit flash_irq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .done_ev   (done_ev),
    .done_any  (done_any),
    .fail_ev   (fail_ev),
    .irq_o     (irq_o),
    .ready_o   (ready_o),
    .cmd_go    (cmd_go),
    .int_q     (int_q),
    .status_q  (status_q),
    .cfg1_q    (cfg1_q)
);

// File: tb/flash_irq_unit_tb.sv
`timescale 1ns/1ps
module flash_irq_unit_tb;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          warm_rst = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [3:0]    done_ev = '0;
    logic          done_any = 1'b0;
    logic [3:0]    fail_ev = '0;
    logic          irq_o, ready_o, cmd_go;
    logic [15:0]   cmd_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_irq_unit #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_ev(done_ev), .done_any(done_any), .fail_ev(fail_ev),
        .irq_o(irq_o), .ready_o(ready_o), .cmd_go(cmd_go), .cmd_code(cmd_code)
    );

    function automatic bit tb_known(input logic [15:0] c);
        logic [7:0] list [17] = '{8'h00, 8'h13, 8'h1A, 8'h1B, 8'h23, 8'h27,
            8'h2A, 8'h2C, 8'h30, 8'h65, 8'h71, 8'h80, 8'h94, 8'h95, 8'hB0,
            8'hF0, 8'hF3};
        if (c[15:8] != 8'h00) return 1'b0;
        foreach (list[k]) if (list[k] == c[7:0]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = AW'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic pulse_done(input logic [3:0] ev, input logic any);
        @(negedge clk);
        done_ev = ev; done_any = any;
        @(negedge clk);
        done_ev = '0; done_any = 1'b0;
    endtask

    task automatic pulse_fail(input logic [3:0] ev);
        @(negedge clk);
        fail_ev = ev;
        @(negedge clk);
        fail_ev = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got 0x0001 expected 0x0000");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 cold reset values
        rd(1, v); check("R1 int", v, 16'h8080);
        rd(0, v); check("R1 status", v, 16'h0000);
        rd(2, v); check("R1 cfg1", v, 16'h40C0);
        rd(3, v); check("R1 cfg2", v, 16'h0000);
        check("R1 ready", {15'b0, ready_o}, 16'h1);
        check("R1 irq", {15'b0, irq_o}, 16'h1);

        // R5 command refused while master set
        wr(4, 16'h0094);
        check("R5 no go", {15'b0, cmd_go}, 16'h0);
        rd(4, v); check("R5 cmd kept", v, 16'h0000);
        rd(0, v); check("R5 status kept", v, 16'h0000);
        wr(4, 16'h0077);
        rd(0, v); check("R5 unknown ignored", v, 16'h0000);

        // R4 AND clear
        wr(1, 16'h7FFF);
        rd(1, v); check("R4 and", v, 16'h0080);

        // R3 polarity x master sweep
        for (int pol = 0; pol < 2; pol++) begin
            for (int m = 0; m < 2; m++) begin
                if (m == 1) pulse_done(4'b0, 1'b1);
                else wr(1, 16'h0000);
                wr(2, 16'(pol << 6) | 16'h0080);
                @(negedge clk);
                check($sformatf("R3 irq pol=%0d m=%0d", pol, m), {15'b0, irq_o},
                      16'((m ^ (1 - pol)) & 1));
            end
        end
        wr(2, 16'h40C0);

        // R6 each event
        for (int i = 0; i < 4; i++) begin
            wr(1, 16'h0000);
            pulse_done(4'(1 << i), 1'b0);
            rd(1, v); check($sformatf("R6 event %0d", i), v, 16'h8000 | 16'(1 << (4 + i)));
        end
        wr(1, 16'h0000);
        pulse_done(4'b0, 1'b1);
        rd(1, v); check("R6 done_any", v, 16'h8000);
        // R6 event beats clearing write
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(1); reg_wdata = 16'h0000; done_ev = 4'b1000;
        @(negedge clk);
        reg_wr = 1'b0; done_ev = '0;
        rd(1, v); check("R6 event wins", v, 16'h8080);

        // R7 fail flags, R4 wipe
        for (int i = 0; i < 4; i++) begin
            wr(1, 16'h0000);
            pulse_fail(4'(1 << i));
            rd(0, v); check($sformatf("R7 fail %0d", i), v, 16'(1 << (10 + i)));
            wr(1, 16'h0000);
            rd(0, v); check($sformatf("R4 wipe %0d", i), v, 16'h0000);
        end
        pulse_fail(4'hF);
        pulse_done(4'b0, 1'b1);
        wr(1, 16'hFFFF);
        rd(0, v); check("R4 kept while master", v, 16'h3C00);
        wr(1, 16'h7FFF);
        rd(0, v); check("R4 wiped on clear", v, 16'h0000);

        // R9 / R8 configuration
        wr(2, 16'hFFFF);
        check("R8 ready hi", {15'b0, ready_o}, 16'h1);
        rd(2, v); check("R9 cfg1 mask", v, 16'hFFE0);
        wr(2, 16'h0000);
        check("R8 ready lo", {15'b0, ready_o}, 16'h0);
        rd(2, v); check("R9 cfg1 zero", v, 16'h0000);
        wr(3, 16'hA5C3);
        rd(3, v); check("R9 cfg2", v, 16'hA5C3);
        wr(2, 16'h40C0);

        // R10 command sweep
        for (int c = 0; c < 258; c++) begin
            logic [15:0] code;
            code = (c < 256) ? 16'(c) : ((c == 256) ? 16'h0100 : 16'h8094);
            wr(1, 16'h0000);
            wr(4, code);
            if (tb_known(code)) begin
                check($sformatf("R10 go %h", code), {15'b0, cmd_go}, 16'h1);
                check($sformatf("R10 code %h", code), cmd_code, code);
                if (code == 16'h00F0 || code == 16'h00F3) begin
                    rd(1, v); check($sformatf("R2 cmd reset %h", code), v, 16'h8010);
                    rd(3, v); check("R2 cfg2 cleared", v, 16'h0000);
                    rd(4, v); check("R2 cmd cleared", v, 16'h0000);
                    wr(3, 16'hA5C3);
                end else begin
                    rd(4, v); check($sformatf("R10 readback %h", code), v, code);
                    rd(0, v); check($sformatf("R10 status %h", code), v, 16'h0000);
                end
            end else begin
                check($sformatf("R10 no go %h", code), {15'b0, cmd_go}, 16'h0);
                rd(0, v); check($sformatf("R10 err %h", code), v, 16'h0400);
                rd(1, v); check($sformatf("R10 master %h", code), v, 16'h8000);
            end
        end

        // R2 warm reset
        wr(1, 16'h0000);
        wr(2, 16'h1234);
        wr(3, 16'h0005);
        pulse_fail(4'h5);
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
        rd(1, v); check("R2 int", v, 16'h8010);
        rd(2, v); check("R2 cfg1", v, 16'h40C0);
        rd(3, v); check("R2 cfg2", v, 16'h0000);
        rd(0, v); check("R2 status", v, 16'h0000);
        check("R2 ready", {15'b0, ready_o}, 16'h1);

        // R11 read path
        rd(7, v); check("R11 unmapped", v, 16'h0000);
        rd(1, v);
        @(negedge clk);
        check("R11 hold", reg_rdata, 16'h8010);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule